// File: doc/BRIEF.md
# Daisy-Chained Storage Cycle Arbiter

This block decides which of several channel slices gets each shared memory cycle, and gives the cycle to the host processor when no slice wants it. Every memory cycle is split into numbered phases that arrive on an input. Each slice collects local requests for a command-word cycle or a data-word cycle. At phase 3 it shows that demand on a shared demand line. It also raises a blocking signal that runs down a serial chain toward the less remote slices. At phase 9 a single grant strobe is issued. The one requesting slice whose upstream blocking input is low takes that strobe. At phase 10 it raises a flag naming the type of the next cycle, command or data.

Slice 0 is the most remote and has the highest priority, and the last slice has the lowest. A slice keeps winning until its pending work is done. A command cycle served while the slice's retain input is high holds the chain for one more command cycle to the same slice, even when a more remote slice is also asking. When no slice shows demand, the host gets the phase-9 cycle instead of the strobe.

Top module: `cyc_arb_chain`

## Requirements
- R1: After synchronous reset, demand, strobe, host cycle, every blocking output, every acceptance and every cycle-type flag are 0.
- R2: A request pulse is recorded at once but shows on the demand line only from the next phase 3. A request that arrives after phase 2 is not visible at phase 8 of the same memory cycle.
- R3: The grant strobe and the host cycle are high only during phase 9, and never both at once.
- R4: Each strobe is accepted by exactly one slice, the most remote slice with a visible request (lowest index). Acceptance shows as a one-cycle pulse on bit i of `acc` during phase 10.
- R5: An accepting slice raises `cmd_flag[i]` for a command cycle or `data_flag[i]` for a data cycle from phase 10. The flag stays up until the end of the next phase 9.
- R6: Inside one slice, a pending command cycle is served before a pending data cycle.
- R7: A slice with several pending cycles keeps priority and is served in back-to-back memory cycles. Its blocking output stays high until the last one is granted.
- R8: A command cycle accepted while `retain[i]` is high gives the next strobe to slice i again as a command cycle. This holds even when a more remote slice is requesting. The hold lasts for one cycle only.
- R9: `blk_out[i]` is high exactly when some slice with index at most i shows a visible request. Bit i belongs to slice i.
- R10: When no slice shows demand, the host cycle is high in phase 9 and no strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | PH_W | Current phase of the memory cycle, 0 to 11 |
| cmd_req | input | N_SLICES | One-clock pulse per slice asking for a command cycle |
| data_req | input | N_SLICES | One-clock pulse per slice asking for a data cycle |
| retain | input | N_SLICES | Level per slice: keep priority for one extra command cycle |
| demand | output | 1 | Shared cycle-demand line |
| grant_stb | output | 1 | Shared grant strobe, phase 9 |
| host_cyc | output | 1 | Host owns this memory cycle, phase 9 |
| blk_out | output | N_SLICES | Blocking signal passed downstream by each slice |
| acc | output | N_SLICES | Strobe accepted, pulse in phase 10 |
| cmd_flag | output | N_SLICES | Next cycle is a command cycle for this slice |
| data_flag | output | N_SLICES | Next cycle is a data cycle for this slice |

## Verification
A lost or stuck pending bit shows up within one memory cycle of twelve clocks. It appears as a missing acceptance, an extra acceptance, or a host cycle while work is still waiting. A wrong entry in the blocking chain shows on `blk_out` at the very next phase 3, and a slice that ignores its block shows as two bits in `acc` in phase 10. A retain hold that fails to clear, or is never taken, changes the owner of the strobe that follows. This is seen one memory cycle after the retained command cycle.

// File: rtl/cyc_arb_pkg.sv
package cyc_arb_pkg;
  localparam int unsigned CYCLE_PHASES = 12;
  localparam int unsigned REQ_PHASE    = 3;
  localparam int unsigned STB_PHASE    = 9;
  localparam int unsigned GATE_PHASE   = STB_PHASE + 1;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_DATA = 2'd2
  } kind_e;
endpackage

// File: rtl/cyc_arb_slice.sv
module cyc_arb_slice
  import cyc_arb_pkg::*;
#(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase,
  input  logic            cmd_set,
  input  logic            data_set,
  input  logic            retain,
  input  logic            blk_in,
  input  logic            retain_busy,
  input  logic            stb,
  output logic            req_vis,
  output logic            blk_out,
  output logic            hold_o,
  output logic            acc_o,
  output logic            cmd_flag,
  output logic            data_flag
);
  localparam logic [PH_W-1:0] PH_SNAP = PH_W'(REQ_PHASE - 1);
  localparam logic [PH_W-1:0] PH_REQ  = PH_W'(REQ_PHASE);
  localparam logic [PH_W-1:0] PH_STB  = PH_W'(STB_PHASE);
  localparam logic [PH_W-1:0] PH_GATE = PH_W'(GATE_PHASE);

  logic  cmd_pend, data_pend, hold_q, req_q, acc_q;
  logic  win;
  kind_e serve_kind;

  // Acceptance: a holding slice owns the strobe; others need a clear chain.
  always_comb begin
    win = stb && (phase == PH_STB) && req_q &&
          (hold_q || (!blk_in && !retain_busy));
    if (!win)                     serve_kind = KIND_NONE;
    else if (hold_q || cmd_pend)  serve_kind = KIND_CMD;
    else if (data_pend)           serve_kind = KIND_DATA;
    else                          serve_kind = KIND_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_pend  <= 1'b0;
      data_pend <= 1'b0;
      hold_q    <= 1'b0;
      req_q     <= 1'b0;
      acc_q     <= 1'b0;
      cmd_flag  <= 1'b0;
      data_flag <= 1'b0;
    end else begin
      cmd_pend  <= (cmd_pend && !(serve_kind == KIND_CMD && !hold_q)) || cmd_set;
      data_pend <= (data_pend && !(serve_kind == KIND_DATA)) || data_set;
      if (phase == PH_SNAP)
        req_q <= cmd_pend || data_pend || hold_q;
      if (phase == PH_STB) begin
        acc_q     <= win;
        cmd_flag  <= (serve_kind == KIND_CMD);
        data_flag <= (serve_kind == KIND_DATA);
        if (win)
          hold_q <= !hold_q && (serve_kind == KIND_CMD) && retain;
      end else begin
        acc_q <= 1'b0;
      end
    end
  end

  assign req_vis = req_q;
  assign blk_out = blk_in || req_q;
  assign hold_o  = hold_q;
  assign acc_o   = acc_q;

  // R2
  req_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> (phase == PH_REQ));
  // R4
  acc_timing_chk: assert property (@(posedge clk) disable iff (rst)
    acc_q |-> (phase == PH_GATE));
  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(cmd_flag && data_flag));
  // R8
  hold_once_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(hold_q) |-> cmd_flag);
endmodule

// File: rtl/cyc_arb_host.sv
module cyc_arb_host
  import cyc_arb_pkg::*;
#(
  parameter int unsigned PH_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] phase,
  input  logic            demand,
  output logic            stb,
  output logic            host_cyc
);
  localparam logic [PH_W-1:0] PH_PRE = PH_W'(STB_PHASE - 1);
  localparam logic [PH_W-1:0] PH_STB = PH_W'(STB_PHASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      stb      <= 1'b0;
      host_cyc <= 1'b0;
    end else if (phase == PH_PRE) begin
      stb      <= demand;
      host_cyc <= !demand;
    end else begin
      stb      <= 1'b0;
      host_cyc <= 1'b0;
    end
  end

  // R3
  stb_host_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(stb && host_cyc));
  // R3
  stb_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (stb || host_cyc) |-> (phase == PH_STB));
endmodule

// File: rtl/cyc_arb_chain.sv
module cyc_arb_chain
  import cyc_arb_pkg::*;
#(
  parameter int unsigned N_SLICES = 8,
  parameter int unsigned PH_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PH_W-1:0]     phase,
  input  logic [N_SLICES-1:0] cmd_req,
  input  logic [N_SLICES-1:0] data_req,
  input  logic [N_SLICES-1:0] retain,
  output logic                demand,
  output logic                grant_stb,
  output logic                host_cyc,
  output logic [N_SLICES-1:0] blk_out,
  output logic [N_SLICES-1:0] acc,
  output logic [N_SLICES-1:0] cmd_flag,
  output logic [N_SLICES-1:0] data_flag
);
  logic [N_SLICES:0]   blk_link;
  logic [N_SLICES-1:0] req_vis;
  logic [N_SLICES-1:0] hold;
  logic                retain_busy;

  assign blk_link[0]  = 1'b0;
  assign demand       = |req_vis;
  assign retain_busy  = |hold;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    cyc_arb_slice #(.PH_W(PH_W)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .phase       (phase),
      .cmd_set     (cmd_req[i]),
      .data_set    (data_req[i]),
      .retain      (retain[i]),
      .blk_in      (blk_link[i]),
      .retain_busy (retain_busy),
      .stb         (grant_stb),
      .req_vis     (req_vis[i]),
      .blk_out     (blk_link[i+1]),
      .hold_o      (hold[i]),
      .acc_o       (acc[i]),
      .cmd_flag    (cmd_flag[i]),
      .data_flag   (data_flag[i])
    );
  end

  assign blk_out = blk_link[N_SLICES:1];

  cyc_arb_host #(.PH_W(PH_W)) u_host (
    .clk      (clk),
    .rst      (rst),
    .phase    (phase),
    .demand   (demand),
    .stb      (grant_stb),
    .host_cyc (host_cyc)
  );

  // R4
  one_acc_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(acc));
  // R4
  acc_after_stb_chk: assert property (@(posedge clk) disable iff (rst)
    grant_stb |=> ($countones(acc) == 1));
  // R5
  flag_owner_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_flag | data_flag));
  // R8
  single_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(hold) <= 1);
  // R10
  host_idle_chk: assert property (@(posedge clk) disable iff (rst)
    host_cyc |-> !demand);
endmodule

// File: tb/tb_cyc_arb_chain.sv
module tb_cyc_arb_chain;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   phase;
  logic [N-1:0] cmd_req = '0, data_req = '0, retain = '0;
  logic         demand, grant_stb, host_cyc;
  logic [N-1:0] blk_out, acc, cmd_flag, data_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) phase <= 4'd0;
    else     phase <= (phase == 4'd11) ? 4'd0 : phase + 4'd1;
  end

  cyc_arb_chain #(.N_SLICES(N), .PH_W(4)) dut (
    .clk(clk), .rst(rst), .phase(phase),
    .cmd_req(cmd_req), .data_req(data_req), .retain(retain),
    .demand(demand), .grant_stb(grant_stb), .host_cyc(host_cyc),
    .blk_out(blk_out), .acc(acc), .cmd_flag(cmd_flag), .data_flag(data_flag)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ph(input int p);
    do @(negedge clk); while (phase != 4'(p));
  endtask

  task automatic pulse(input logic [N-1:0] cm, input logic [N-1:0] dm);
    cmd_req  = cm;
    data_req = dm;
    @(negedge clk);
    cmd_req  = '0;
    data_req = '0;
  endtask

  // s < 0: host cycle expected
  task automatic serve_check(input int s, input bit is_cmd, input string req);
    logic [N-1:0] e;
    wait_ph(9);
    if (s < 0) chk(host_cyc && !grant_stb, req, {host_cyc, grant_stb}, 2'b10);
    else       chk(grant_stb && !host_cyc, req, {host_cyc, grant_stb}, 2'b01);
    wait_ph(10);
    e = (s < 0) ? '0 : N'(1) << s;
    chk(acc == e, req, acc, e);
    chk(cmd_flag == (is_cmd ? e : '0), req, cmd_flag, is_cmd ? e : '0);
    chk(data_flag == (is_cmd ? '0 : e), req, data_flag, is_cmd ? '0 : e);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!demand && !grant_stb && !host_cyc, "R1", {demand, grant_stb, host_cyc}, 0);
    chk(blk_out == 0 && acc == 0, "R1", {blk_out, acc}, 0);
    chk(cmd_flag == 0 && data_flag == 0, "R1", {cmd_flag, data_flag}, 0);
  endtask

  task automatic t_late_request;
    wait_ph(5);
    pulse(8'h08, 8'h00);
    wait_ph(8);
    chk(demand == 1'b0, "R2", demand, 0);
    serve_check(-1, 1'b0, "R10");
    wait_ph(3);
    chk(demand == 1'b1, "R2", demand, 1);
    chk(blk_out == 8'hF8, "R9", blk_out, 8'hF8);
    serve_check(3, 1'b1, "R5");
    wait_ph(9);
    chk(cmd_flag == 8'h08 && host_cyc, "R5", cmd_flag, 8'h08);
    wait_ph(10);
    chk(cmd_flag == 8'h00, "R5", cmd_flag, 0);
  endtask

  task automatic t_priority;
    wait_ph(0);
    pulse(8'h12, 8'h40);
    wait_ph(3);
    chk(blk_out == 8'hFE, "R9", blk_out, 8'hFE);
    serve_check(1, 1'b1, "R4");
    serve_check(4, 1'b1, "R4");
    serve_check(6, 1'b0, "R4");
    serve_check(-1, 1'b0, "R10");
  endtask

  task automatic t_same_slice;
    wait_ph(0);
    pulse(8'h04, 8'h24);
    serve_check(2, 1'b1, "R6");
    wait_ph(3);
    chk(blk_out == 8'hFC, "R7", blk_out, 8'hFC);
    serve_check(2, 1'b0, "R7");
    serve_check(5, 1'b0, "R7");
    serve_check(-1, 1'b0, "R7");
  endtask

  task automatic t_edges;
    wait_ph(0);
    pulse(8'h00, 8'h80);
    wait_ph(3);
    chk(blk_out == 8'h80, "R9", blk_out, 8'h80);
    serve_check(7, 1'b0, "R9");
    wait_ph(0);
    pulse(8'h80, 8'h01);
    wait_ph(3);
    chk(blk_out == 8'hFF, "R9", blk_out, 8'hFF);
    serve_check(0, 1'b0, "R4");
    serve_check(7, 1'b1, "R4");
  endtask

  task automatic t_retain;
    wait_ph(0);
    retain = 8'h10;
    pulse(8'h10, 8'h00);
    serve_check(4, 1'b1, "R8");
    retain = 8'h00;
    pulse(8'h02, 8'h00);
    serve_check(4, 1'b1, "R8");
    serve_check(1, 1'b1, "R8");
    serve_check(-1, 1'b0, "R8");
    wait_ph(0);
    retain = 8'h40;
    pulse(8'h40, 8'h00);
    serve_check(6, 1'b1, "R8");
    retain = 8'h00;
    serve_check(6, 1'b1, "R8");
    serve_check(-1, 1'b0, "R8");
  endtask

  task automatic t_idle;
    int n_stb = 0;
    int n_host = 0;
    int n_off = 0;
    wait_ph(0);
    for (int k = 0; k < 36; k++) begin
      @(negedge clk);
      if (grant_stb) n_stb++;
      if (host_cyc) begin
        n_host++;
        if (phase != 4'd9) n_off++;
      end
    end
    chk(n_stb == 0, "R10", n_stb, 0);
    chk(n_host == 3, "R3", n_host, 3);
    chk(n_off == 0, "R3", n_off, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_late_request();
    t_priority();
    t_same_slice();
    t_edges();
    t_retain();
    t_idle();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule